// File: doc/BRIEF.md
# Multi-Mode Operand Address Resolver

This block turns an instruction's operand specifier into either an effective address or an immediate value. It takes a 3-bit mode code, an address field, a register selector and a relative flag. It holds its own small register file: `NGPR` general registers plus a program counter, all loaded through a simple write port. Seven of the modes are resolved combinationally and registered, so the result appears in the cycle after the request. Memory-indirect mode first sends a one-cycle pointer read to memory. It then waits for the returned word and presents that word as the effective address in the cycle after it arrives.

The control is one state machine with three states. **S_IDLE** accepts a request. **S_PTR_WAIT** waits for the pointer word. **S_DONE** is the single cycle in which `out_valid` is high. The transitions are:
- **accept-direct**: S_IDLE to S_DONE, for every mode except indirect.
- **accept-indirect**: S_IDLE to S_PTR_WAIT.
- **ptr-return**: S_PTR_WAIT to S_DONE, on `mem_rvalid`.
- **retire**: S_DONE to S_IDLE.

Requests that arrive outside S_IDLE are dropped. The post-increment variant of register-indirect bumps the selected register on the edge that accepts the request.

Top module: `ea_resolver`

## Requirements
- R1: After reset, `out_valid` and `mem_rd` are low and every register, including the program counter, reads as zero.
- R2: With mode 1 (immediate), the cycle after acceptance shows `out_valid`=1, `out_kind`=1 (immediate) and `out_value` equal to the zero-extended field, and no memory read is issued.
- R3: With mode 0 (implied), the result has `out_kind`=2 (no location) and `out_value`=0 whatever the field holds.
- R4: With mode 4 (direct), the result has `out_kind`=0 (address) and a value equal to the zero-extended field.
- R5: With mode 5 (indirect), `mem_rd` is high for exactly the cycle after acceptance, with `mem_addr` equal to the zero-extended field. The cycle after `mem_rvalid` is sampled shows `out_valid` with `out_kind`=0 and `out_value` equal to `mem_rdata`.
- R6: With mode 2 (register-indirect), the result is the selected register's content, and the register is left unchanged.
- R7: With mode 3 (register-indirect, post-increment), the result is the register's old content, and the register becomes that value plus 1, wrapping 0xFFFF to 0x0000.
- R8: With mode 6 (indexed), the result is the zero-extended field plus the selected register, modulo 2^AW.
- R9: With mode 7 (base register), the result is the selected register plus the zero-extended field used as an offset, modulo 2^AW.
- R10: When `rel_sel` is 1, the mode is ignored. The result is the program counter plus the sign-extended field, modulo 2^AW, with no memory read and no increment.
- R11: A request is accepted only in S_IDLE. Requests during S_PTR_WAIT or S_DONE have no effect.
- R12: When `wr_en` is 1, register `wr_idx` is loaded for later requests. Indices 0..NGPR-1 are the general registers, index NGPR is the program counter, and larger indices are ignored. On the same edge as a post-increment of the same register, the external write wins.
- R13: `out_valid` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Resolve request |
| mode | input | 3 | Addressing mode code |
| rel_sel | input | 1 | Relative addressing override |
| addr_fld | input | FW | Instruction address field |
| reg_sel | input | $clog2(NGPR) | General register selector |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | $clog2(NGPR+1) | Register write index (NGPR = program counter) |
| wr_data | input | AW | Register write data |
| mem_rd | output | 1 | Pointer read strobe |
| mem_addr | output | AW | Pointer read address |
| mem_rvalid | input | 1 | Pointer word returned |
| mem_rdata | input | AW | Pointer word |
| out_valid | output | 1 | Result valid pulse |
| out_value | output | AW | Effective address or immediate value |
| out_kind | output | 2 | 0 address, 1 immediate, 2 no location |

## Verification
The hardest case to reach from the ports is an external register write that lands on the same edge as a post-increment of that same register. The stimulus creates it by raising `wr_en` in the very cycle that a mode 3 request is accepted. A later mode 2 read of that register shows which update won. Requests made while a pointer read is outstanding are also provoked on purpose. The stimulus holds off `mem_rvalid` for several cycles and fires a direct request in the gap. It also holds `req` high across S_DONE so that exactly every second cycle is accepted.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        M_IMPL = 3'd0,
        M_IMM  = 3'd1,
        M_RIND = 3'd2,
        M_RINC = 3'd3,
        M_DIR  = 3'd4,
        M_IND  = 3'd5,
        M_IDX  = 3'd6,
        M_BASE = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        K_ADDR = 2'd0,
        K_IMM  = 2'd1,
        K_NONE = 2'd2
    } okind_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_PTR_WAIT = 2'd1,
        S_DONE     = 2'd2
    } st_e;

endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
    parameter int AW   = 16,
    parameter int NGPR = 8,
    parameter int SELW = 3,
    parameter int WIW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WIW-1:0]  wr_idx,
    input  logic [AW-1:0]   wr_data,
    input  logic            inc_en,
    input  logic [SELW-1:0] inc_sel,
    input  logic [SELW-1:0] rd_sel,
    output logic [AW-1:0]   rd_val,
    output logic [AW-1:0]   pc_val
);

    logic [AW-1:0] flat [NGPR+1];

    for (genvar g = 0; g <= NGPR; g++) begin : g_ent
        logic [AW-1:0] q;
        logic          bump;

        if (g < NGPR) begin : g_gpr
            assign bump = inc_en && (inc_sel == SELW'(g));
        end else begin : g_pc
            assign bump = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_idx == WIW'(g)))
                q <= wr_data;
            else if (bump)
                q <= q + AW'(1);
        end

        assign flat[g] = q;
    end

    assign rd_val = flat[rd_sel];
    assign pc_val = flat[NGPR];

endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int FW = 12
) (
    input  logic [2:0]    mode,
    input  logic          rel_sel,
    input  logic [FW-1:0] fld,
    input  logic [AW-1:0] reg_val,
    input  logic [AW-1:0] pc_val,
    output logic [AW-1:0] value,
    output okind_e        kind,
    output logic          need_ptr,
    output logic          post_inc
);

    localparam int EXT = AW - FW;

    logic [AW-1:0] fld_z;
    logic [AW-1:0] fld_s;

    assign fld_z = {{EXT{1'b0}}, fld};
    assign fld_s = {{EXT{fld[FW-1]}}, fld};

    always_comb begin
        value    = fld_z;
        kind     = K_ADDR;
        need_ptr = 1'b0;
        post_inc = 1'b0;
        if (rel_sel) begin
            value = pc_val + fld_s;
        end else begin
            unique case (amode_e'(mode))
                M_IMPL: begin value = '0; kind = K_NONE; end
                M_IMM:  kind = K_IMM;
                M_RIND: value = reg_val;
                M_RINC: begin value = reg_val; post_inc = 1'b1; end
                M_DIR:  value = fld_z;
                M_IND:  need_ptr = 1'b1;
                M_IDX:  value = fld_z + reg_val;
                M_BASE: value = reg_val + fld_z;
                default: value = fld_z;
            endcase
        end
    end

endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] calc_value,
    input  okind_e        calc_kind,
    input  logic          need_ptr,
    input  logic          post_inc,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata,
    output logic          out_valid,
    output logic [AW-1:0] out_value,
    output okind_e        out_kind,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic          inc_fire,
    output st_e           st
);

    st_e  st_nx;
    logic accept;

    assign accept   = (st == S_IDLE) && req;
    assign inc_fire = accept && post_inc;

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:     if (req) st_nx = need_ptr ? S_PTR_WAIT : S_DONE;
            S_PTR_WAIT: if (mem_rvalid) st_nx = S_DONE;
            S_DONE:     st_nx = S_IDLE;
            default:    st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= S_IDLE;
        else
            st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_value <= '0;
            out_kind  <= K_ADDR;
            mem_rd    <= 1'b0;
            mem_addr  <= '0;
        end else begin
            out_valid <= 1'b0;
            mem_rd    <= 1'b0;
            if (accept) begin
                if (need_ptr) begin
                    mem_rd   <= 1'b1;
                    mem_addr <= calc_value;
                end else begin
                    out_valid <= 1'b1;
                    out_value <= calc_value;
                    out_kind  <= calc_kind;
                end
            end else if ((st == S_PTR_WAIT) && mem_rvalid) begin
                out_valid <= 1'b1;
                out_value <= mem_rdata;
                out_kind  <= K_ADDR;
            end
        end
    end

endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
    import ea_pkg::*;
#(
    parameter int AW   = 16,
    parameter int FW   = 12,
    parameter int NGPR = 8,
    localparam int SELW = $clog2(NGPR),
    localparam int WIW  = $clog2(NGPR + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [2:0]      mode,
    input  logic            rel_sel,
    input  logic [FW-1:0]   addr_fld,
    input  logic [SELW-1:0] reg_sel,
    input  logic            wr_en,
    input  logic [WIW-1:0]  wr_idx,
    input  logic [AW-1:0]   wr_data,
    output logic            mem_rd,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_rvalid,
    input  logic [AW-1:0]   mem_rdata,
    output logic            out_valid,
    output logic [AW-1:0]   out_value,
    output logic [1:0]      out_kind
);

    logic [AW-1:0] reg_val;
    logic [AW-1:0] pc_val;
    logic [AW-1:0] calc_value;
    okind_e        calc_kind;
    okind_e        kind_q;
    logic          need_ptr;
    logic          post_inc;
    logic          inc_fire;
    st_e           st;
    logic [1:0]    st_w;

    ea_regfile #(.AW(AW), .NGPR(NGPR), .SELW(SELW), .WIW(WIW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .inc_en  (inc_fire),
        .inc_sel (reg_sel),
        .rd_sel  (reg_sel),
        .rd_val  (reg_val),
        .pc_val  (pc_val)
    );

    ea_calc #(.AW(AW), .FW(FW)) u_calc (
        .mode     (mode),
        .rel_sel  (rel_sel),
        .fld      (addr_fld),
        .reg_val  (reg_val),
        .pc_val   (pc_val),
        .value    (calc_value),
        .kind     (calc_kind),
        .need_ptr (need_ptr),
        .post_inc (post_inc)
    );

    ea_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .calc_value (calc_value),
        .calc_kind  (calc_kind),
        .need_ptr   (need_ptr),
        .post_inc   (post_inc),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .out_valid  (out_valid),
        .out_value  (out_value),
        .out_kind   (kind_q),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .inc_fire   (inc_fire),
        .st         (st)
    );

    assign out_kind = kind_q;
    assign st_w     = st;

endmodule

// File: rtl/ea_resolver_chk.sv
module ea_resolver_chk
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int FW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic [2:0]    mode,
    input logic          rel_sel,
    input logic [FW-1:0] addr_fld,
    input logic          mem_rd,
    input logic          mem_rvalid,
    input logic [AW-1:0] mem_rdata,
    input logic          out_valid,
    input logic [AW-1:0] out_value,
    input logic [1:0]    out_kind,
    input logic [1:0]    st
);

    logic take;
    assign take = (st == 2'(S_IDLE)) && req && !rel_sel;

    // R13
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R5
    rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode == 3'd5) |=> (mem_rd && !out_valid));

    // R5
    ptr_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'(S_PTR_WAIT) && mem_rvalid) |=>
            (out_valid && out_kind == 2'd0 && out_value == $past(mem_rdata)));

    // R2
    imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode == 3'd1) |=>
            (out_valid && !mem_rd && out_kind == 2'd1 && out_value == AW'($past(addr_fld))));

    // R3
    impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode == 3'd0) |=> (out_valid && out_kind == 2'd2 && out_value == '0));

    // R4
    dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode == 3'd4) |=>
            (out_valid && out_kind == 2'd0 && out_value == AW'($past(addr_fld))));

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'(S_DONE)) |=> (!out_valid && !mem_rd));

endmodule

bind ea_resolver ea_resolver_chk #(.AW(AW), .FW(FW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .mode       (mode),
    .rel_sel    (rel_sel),
    .addr_fld   (addr_fld),
    .mem_rd     (mem_rd),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .out_valid  (out_valid),
    .out_value  (out_value),
    .out_kind   (out_kind),
    .st         (st_w)
);

// File: tb/sim_ea_resolver.sv
module sim_ea_resolver;

    localparam int AW = 16;
    localparam int FW = 12;
    localparam int NG = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  mode = '0;
    logic        rel_sel = 1'b0;
    logic [11:0] addr_fld = '0;
    logic [2:0]  reg_sel = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic        out_valid;
    logic [15:0] out_value;
    logic [1:0]  out_kind;

    always #10 clk = ~clk;

    ea_resolver #(.AW(AW), .FW(FW), .NGPR(NG)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .rel_sel(rel_sel),
        .addr_fld(addr_fld), .reg_sel(reg_sel), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_value(out_value), .out_kind(out_kind)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    started = 0;
    bit    done_run = 0;

    // behavioural reference
    int   ms = 0;
    bit   e_valid = 0, e_rd = 0;
    int   e_val = 0, e_kind = 0, e_addr = 0;
    int   mr [NG+1];
    int   c_val, c_kind;
    bit   c_ind, c_inc;

    function automatic void ref_calc(int md, bit rel, int fld, int rv, int pc,
                                     output int v, output int k,
                                     output bit ind, output bit inc);
        int ofs;
        ind = 0; inc = 0; k = 0; v = fld;
        if (rel) begin
            ofs = (fld >= 2048) ? fld - 4096 : fld;
            v = (pc + ofs) & 16'hFFFF;
        end else begin
            case (md)
                0: begin v = 0; k = 2; end
                1: k = 1;
                2: v = rv;
                3: begin v = rv; inc = 1; end
                4: v = fld;
                5: ind = 1;
                6: v = (fld + rv) % 65536;
                default: v = (rv + fld) % 65536;
            endcase
        end
    endfunction

    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (!rst_n) begin
            ms = 0; e_valid = 0; e_rd = 0;
            for (int i = 0; i <= NG; i++) mr[i] = 0;
        end else begin
            case (ms)
                0: begin
                    e_valid = 0; e_rd = 0;
                    if (req) begin
                        ref_calc(int'(mode), rel_sel, int'(addr_fld), mr[reg_sel], mr[NG],
                                 c_val, c_kind, c_ind, c_inc);
                        if (c_ind) begin
                            ms = 2; e_rd = 1; e_addr = c_val;
                        end else begin
                            ms = 1; e_valid = 1; e_val = c_val; e_kind = c_kind;
                        end
                        if (c_inc) mr[reg_sel] = (mr[reg_sel] + 1) % 65536;
                    end
                end
                1: begin e_valid = 0; e_rd = 0; ms = 0; end
                default: begin
                    e_rd = 0;
                    if (mem_rvalid) begin
                        ms = 1; e_valid = 1; e_val = int'(mem_rdata); e_kind = 0;
                    end
                end
            endcase
            if (wr_en && wr_idx <= 4'(NG)) mr[wr_idx] = int'(wr_data);
        end
    end

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done_run) begin
            chk("out_valid", int'(out_valid), int'(e_valid));
            chk("mem_rd", int'(mem_rd), int'(e_rd));
            if (e_valid) begin
                chk("out_value", int'(out_value), e_val);
                chk("out_kind", int'(out_kind), e_kind);
            end
            if (e_rd) chk("mem_addr", int'(mem_addr), e_addr);
        end
    end

    task automatic finish_run();
        done_run = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 20000 && !done_run) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog run did not end actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    task automatic wr(int idx, int data);
        @(negedge clk);
        wr_en = 1; wr_idx = 4'(idx); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rq(int md, bit rel, int fld, int sel);
        @(negedge clk);
        req = 1; mode = 3'(md); rel_sel = rel; addr_fld = 12'(fld); reg_sel = 3'(sel);
        @(negedge clk);
        req = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic ind(int fld, int lat, int data);
        @(negedge clk);
        req = 1; mode = 3'd5; rel_sel = 0; addr_fld = 12'(fld);
        @(negedge clk);
        req = 0;
        repeat (lat) @(negedge clk);
        mem_rvalid = 1; mem_rdata = 16'(data);
        @(negedge clk);
        mem_rvalid = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        rq(2, 0, 0, 3);                 // R1 registers start at zero
        rq(2, 1 - 1, 0, 7);
        cur_req = "R12";
        wr(1, 16'h1234); wr(2, 16'hFFFF); wr(5, 16'h00F0);
        wr(6, 16'hFFF8); wr(NG, 16'hFFF0);
        wr(12, 16'h7777);               // R12 out-of-range index ignored
        rq(2, 0, 0, 1);
        cur_req = "R2";
        rq(1, 0, 12'hABC, 0); rq(1, 0, 12'hFFF, 4);
        cur_req = "R3";
        rq(0, 0, 12'h555, 2);
        cur_req = "R4";
        rq(4, 0, 12'h800, 0);
        cur_req = "R5";
        ind(12'h123, 3, 16'hBEEF); ind(12'hF00, 0, 16'h0001);
        cur_req = "R6";
        rq(2, 0, 0, 1); rq(2, 0, 12'h3FF, 1);
        cur_req = "R7";
        rq(3, 0, 0, 2); rq(2, 0, 0, 2); rq(3, 0, 0, 1); rq(2, 0, 0, 1);
        cur_req = "R8";
        rq(6, 0, 12'h010, 1); rq(6, 0, 12'h00A, 6);
        cur_req = "R9";
        rq(7, 0, 12'hF00, 5); rq(7, 0, 12'hFFF, 6);
        cur_req = "R10";
        rq(0, 1, 12'h020, 0); rq(1, 1, 12'hFF0, 0);
        rq(3, 1, 12'h001, 1); rq(2, 0, 0, 1);
        rq(5, 1, 12'h004, 0);
        wr(NG, 16'h8000); rq(4, 1, 12'h800, 0);
        cur_req = "R11";
        @(negedge clk);
        req = 1; mode = 3'd5; rel_sel = 0; addr_fld = 12'h044;
        @(negedge clk);
        mode = 3'd4; addr_fld = 12'h099;
        repeat (3) @(negedge clk);
        req = 0; mem_rvalid = 1; mem_rdata = 16'h4242;
        @(negedge clk);
        mem_rvalid = 0;
        repeat (2) @(negedge clk);
        req = 1; mode = 3'd1; addr_fld = 12'h011;
        repeat (5) @(negedge clk);
        req = 0;
        repeat (3) @(negedge clk);
        cur_req = "R12";
        @(negedge clk);
        req = 1; mode = 3'd3; reg_sel = 3'd3; rel_sel = 0;
        wr_en = 1; wr_idx = 4'd3; wr_data = 16'h0100;
        @(negedge clk);
        req = 0; wr_en = 0;
        repeat (2) @(negedge clk);
        rq(2, 0, 0, 3);
        cur_req = "R13";
        @(negedge clk);
        req = 1; mode = 3'd4; addr_fld = 12'h00C;
        repeat (6) @(negedge clk);
        req = 0;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        rq(2, 0, 0, 1);
        finish_run();
    end

endmodule